// File: doc/BRIEF.md
# Decade Counter with Seven-Segment Outputs

This block counts rising edges of a slow count input from 0 to 9 and wraps around. It presents the current digit on seven active-high segment lines suited to a common-cathode display. The count input is treated as an asynchronous signal. It is passed through a synchronizer and edge-detected inside a single system clock domain, so the count changes on system clock edges only.

Alongside the segments it provides a divide-by-ten output for cascading into another instance, a flag that drops only while the digit is two, and a one-cycle-delayed copy of the display enable. A clear input forces the count to zero. A hold input freezes the count. The display enable blanks the segments without stopping the count.

Top module: `decade_seg_counter`

## Requirements
- R1: Each rising edge of `cnt_in` advances the count by exactly one, and 9 is followed by 0. A level held high gives only one step.
- R2: While `clr` is high the count is zero. `clr` wins over `hold`, and an edge of `cnt_in` that falls inside a clear is discarded.
- R3: While `hold` is high, edges of `cnt_in` are ignored and the count keeps its value.
- R4: `seg[0]` through `seg[6]` are segments a through g, active high. Digits 0..9 read 7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07, 7'h7F and 7'h6F. Digit 6 lights a, digit 9 lights d, and digit 7 lights only a, b and c.
- R5: While `disp_en` is low, `seg` is 7'h00, and the count still advances.
- R6: `disp_en_echo` equals the value `disp_en` had one system clock earlier.
- R7: `div10` is high for counts 0 to 4 and low for counts 5 to 9.
- R8: `not_two` is low only while the count is 2.
- R9: A rising edge of `cnt_in` takes two synchronizer stages. The count changes on the third `clk` rising edge after `cnt_in` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr | input | 1 | Synchronous clear of the count, active high |
| cnt_in | input | 1 | Asynchronous count input; rising edges are counted |
| hold | input | 1 | Freezes the count while high |
| disp_en | input | 1 | Segment enable; low blanks the display |
| seg | output | 7 | Segments a..g on bits 0..6, active high |
| div10 | output | 1 | High for counts 0..4, low for 5..9 |
| not_two | output | 1 | Low only at count 2 |
| disp_en_echo | output | 1 | `disp_en` delayed by one clock |

## Verification
The bench walks all ten digits and goes past the 9-to-0 wrap. A counter that skipped the wrap would show 10 as a blank or garbage pattern. It holds `cnt_in` high over many clocks, which catches a level-sensitive design that counts on every clock. It raises `cnt_in` during a clear and while `hold` is set. A design with the wrong priority, or one that kept a pending edge, would step once these were released. It also samples the count between the second and third clock edge after an input edge, and the echo before and after one clock. A missing synchronizer stage, or an extra one, would move these changes by a cycle.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  localparam int unsigned DSC_MOD   = 10;
  localparam int unsigned DSC_CNT_W = $clog2(DSC_MOD);
  localparam int unsigned DSC_SEG_W = 7;

  typedef logic [DSC_CNT_W-1:0] digit_t;
  typedef logic [DSC_SEG_W-1:0] seg_t;

  // Next value of a modulo counter.
  function automatic digit_t f_next(input digit_t d);
    return (d == digit_t'(DSC_MOD - 1)) ? '0 : digit_t'(d + 1'b1);
  endfunction

  // Segment pattern, bit 0 = a ... bit 6 = g.
  function automatic seg_t f_seg(input digit_t d);
    seg_t s;
    case (d)
      digit_t'(0): s = 7'h3F;
      digit_t'(1): s = 7'h06;
      digit_t'(2): s = 7'h5B;
      digit_t'(3): s = 7'h4F;
      digit_t'(4): s = 7'h66;
      digit_t'(5): s = 7'h6D;
      digit_t'(6): s = 7'h7D;
      digit_t'(7): s = 7'h07;
      digit_t'(8): s = 7'h7F;
      digit_t'(9): s = 7'h6F;
      default:     s = 7'h00;
    endcase
    return s;
  endfunction

  // Lower half of the cycle drives the divided output high.
  function automatic logic f_low_half(input digit_t d);
    return (d < digit_t'(DSC_MOD / 2));
  endfunction

endpackage

// File: rtl/dsc_sync_edge.sv
module dsc_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic din,
  output logic rise
);
  localparam int unsigned TAPS = STAGES + 1;

  logic [TAPS-1:0] sh_q;

  // All taps preset high on clear so no edge is seen while clear lasts
  // or just after it.
  always_ff @(posedge clk) begin
    if (clr) begin
      sh_q <= '1;
    end else begin
      sh_q <= {sh_q[TAPS-2:0], din};
    end
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/dsc_decade_core.sv
module dsc_decade_core
  import dsc_pkg::*;
(
  input  logic   clk,
  input  logic   clr,
  input  logic   hold,
  input  logic   step,
  output digit_t cnt
);
  digit_t cnt_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q <= '0;
    end else if (step && !hold) begin
      cnt_q <= f_next(cnt_q);
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/dsc_seg_decode.sv
module dsc_seg_decode
  import dsc_pkg::*;
(
  input  logic   clk,
  input  digit_t cnt,
  input  logic   disp_en,
  output seg_t   seg,
  output logic   div10,
  output logic   not_two,
  output logic   disp_en_echo
);
  logic echo_q;

  // The echo register runs free of the clear so it always tracks disp_en.
  always_ff @(posedge clk) begin
    echo_q <= disp_en;
  end

  always_comb begin
    seg     = disp_en ? f_seg(cnt) : '0;
    div10   = f_low_half(cnt);
    not_two = (cnt != digit_t'(2));
  end

  assign disp_en_echo = echo_q;

endmodule

// File: rtl/decade_seg_counter.sv
module decade_seg_counter
  import dsc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       clr,
  input  logic       cnt_in,
  input  logic       hold,
  input  logic       disp_en,
  output logic [6:0] seg,
  output logic       div10,
  output logic       not_two,
  output logic       disp_en_echo
);
  logic   edge_evt;
  digit_t cnt_q;

  dsc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .clr  (clr),
    .din  (cnt_in),
    .rise (edge_evt)
  );

  dsc_decade_core u_core (
    .clk  (clk),
    .clr  (clr),
    .hold (hold),
    .step (edge_evt),
    .cnt  (cnt_q)
  );

  dsc_seg_decode u_dec (
    .clk          (clk),
    .cnt          (cnt_q),
    .disp_en      (disp_en),
    .seg          (seg),
    .div10        (div10),
    .not_two      (not_two),
    .disp_en_echo (disp_en_echo)
  );

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             clr,
  input logic             hold,
  input logic             disp_en,
  input logic             disp_en_echo,
  input logic [6:0]       seg,
  input logic             div10,
  input logic             not_two,
  input logic             edge_evt,
  input logic [CNT_W-1:0] cnt
);
  p_step_r1: assert property (@(posedge clk) disable iff (clr)
    (edge_evt && !hold && cnt < CNT_W'(9)) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  p_wrap_r1: assert property (@(posedge clk) disable iff (clr)
    (edge_evt && !hold && cnt == CNT_W'(9)) |=> (cnt == '0));

  p_clear_r2: assert property (@(posedge clk)
    clr |=> (cnt == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (clr)
    hold |=> $stable(cnt));

  p_noedge_r1: assert property (@(posedge clk) disable iff (clr)
    !edge_evt |=> $stable(cnt));

  p_blank_r5: assert property (@(posedge clk) disable iff (clr)
    !disp_en |-> (seg == 7'h00));

  p_echo_r6: assert property (@(posedge clk) disable iff (clr)
    1'b1 |=> (disp_en_echo == $past(disp_en)));

  p_div_fall_r7: assert property (@(posedge clk) disable iff (clr)
    $fell(div10) |-> (cnt == CNT_W'(5)));

  p_not_two_r8: assert property (@(posedge clk) disable iff (clr)
    $fell(not_two) |-> (cnt == CNT_W'(2)));

endmodule

bind decade_seg_counter dsc_checker #(.CNT_W(dsc_pkg::DSC_CNT_W)) u_chk (
  .clk          (clk),
  .clr          (clr),
  .hold         (hold),
  .disp_en      (disp_en),
  .disp_en_echo (disp_en_echo),
  .seg          (seg),
  .div10        (div10),
  .not_two      (not_two),
  .edge_evt     (edge_evt),
  .cnt          (cnt_q)
);

// File: tb/decade_seg_counter_bench.sv
module decade_seg_counter_bench;

  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       cnt_in = 1'b0;
  logic       hold = 1'b0;
  logic       disp_en = 1'b1;
  logic [6:0] seg;
  logic       div10;
  logic       not_two;
  logic       disp_en_echo;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Per digit: {segments a..g, div10, not_two}
  localparam logic [8:0] EXP [10] = '{
    {7'h3F, 1'b1, 1'b1}, {7'h06, 1'b1, 1'b1}, {7'h5B, 1'b1, 1'b0},
    {7'h4F, 1'b1, 1'b1}, {7'h66, 1'b1, 1'b1}, {7'h6D, 1'b0, 1'b1},
    {7'h7D, 1'b0, 1'b1}, {7'h07, 1'b0, 1'b1}, {7'h7F, 1'b0, 1'b1},
    {7'h6F, 1'b0, 1'b1}
  };

  decade_seg_counter u_decade_seg_counter (
    .clk(clk), .clr(clr), .cnt_in(cnt_in), .hold(hold), .disp_en(disp_en),
    .seg(seg), .div10(div10), .not_two(not_two), .disp_en_echo(disp_en_echo)
  );

  always #5 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic pulse();
    cnt_in = 1'b1; tick(4);
    cnt_in = 1'b0; tick(4);
  endtask

  task automatic check_digit(input string req, input int d);
    check(req, int'({seg, div10, not_two}), int'(EXP[d]));
  endtask

  initial begin
    tick(4);
    check_digit("R2 reset state", 0);
    clr = 1'b0; tick(2);

    // R1 R4 R7 R8: walk all digits and the wrap
    for (int k = 1; k <= 12; k++) begin
      pulse();
      check_digit("R1/R4/R7/R8 table", k % 10);
    end

    // R1: a long high level counts once
    cnt_in = 1'b1; tick(30);
    check_digit("R1 level held", 3);
    cnt_in = 1'b0; tick(4);

    // R9: count changes on the third clock edge
    cnt_in = 1'b1; tick(2);
    check_digit("R9 not yet after two edges", 3);
    tick(1);
    check_digit("R9 changed on third edge", 4);
    tick(3); cnt_in = 1'b0; tick(4);

    // R3: hold freezes the count
    hold = 1'b1; pulse(); pulse();
    check_digit("R3 hold ignores edges", 4);
    hold = 1'b0; tick(2);
    check_digit("R3 no pending step after hold", 4);

    // R5: blanking, count keeps going
    disp_en = 1'b0; tick(1);
    check("R5 blank", int'(seg), 0);
    pulse();
    check("R5 still blank", int'(seg), 0);
    disp_en = 1'b1; tick(1);
    check_digit("R5 counted while blank", 5);

    // R6: echo delay
    disp_en = 1'b0; #1;
    check("R6 echo before edge", int'(disp_en_echo), 1);
    tick(1);
    check("R6 echo after edge", int'(disp_en_echo), 0);
    disp_en = 1'b1; tick(1);
    check("R6 echo follows high", int'(disp_en_echo), 1);

    // R2: clear beats hold, edge inside clear discarded
    hold = 1'b1; clr = 1'b1; tick(2);
    check_digit("R2 clear over hold", 0);
    hold = 1'b0; cnt_in = 1'b1; tick(4);
    clr = 1'b0; tick(6);
    check_digit("R2 edge in clear dropped", 0);
    cnt_in = 1'b0; tick(4);
    pulse();
    check_digit("R2 counts after clear", 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule